// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two parallel buses, A and B, and either passes data straight across or drives one bus from a stored word. Each side has its own capture register. The A-side register samples bus A, and the B-side register samples bus B. For each transfer direction, a select input chooses whether the driven bus gets the live value from the other bus or the word held in that other bus's register.

An active-low transfer enable and a direction input decide which bus, if any, the block drives. Each bus is modelled as three separate vectors, all inside one clock domain, in place of tri-state pins:
- a value coming in,
- a value going out,
- a per-bit output enable.

The capture strobes are ordinary inputs sampled on the system clock. A low-to-high change between two samples loads the matching register. Captures do not depend on the enable or direction state. A build parameter complements every path to the driven bus.

Top module: `regbus_xcvr`

## Requirements
- R1: A rising edge of `grab_a` (high on this clock, low on the previous clock) stores the current A-bus value into the A-side register at that clock edge.
- R2: A rising edge of `grab_b` stores the current B-bus value into the B-side register at that clock edge.
- R3: While `xfer_en_n` is 1, every bit of `a_oe` and `b_oe` is 0.
- R4: With `xfer_en_n`=0 and `dir_to_b`=0, all bits of `a_oe` are 1 and all bits of `b_oe` are 0. If `use_stored_ba`=0, `a_out` follows `b_in` in the same cycle, with no clock delay.
- R5: With `xfer_en_n`=0, `dir_to_b`=0 and `use_stored_ba`=1, `a_out` shows the B-side register.
- R6: With `xfer_en_n`=0 and `dir_to_b`=1, all bits of `b_oe` are 1 and all bits of `a_oe` are 0. `b_out` shows `a_in` when `use_stored_ab`=0 and the A-side register when `use_stored_ab`=1.
- R7: Captures happen whatever the enable and direction state, including while neither bus is driven. Both strobes may rise on the same clock, and both registers then load.
- R8: On a clock without a rising edge of its strobe, a register keeps its value, even if the bus value changes.
- R9: With `INVERT`=1, the driven bus carries the bitwise complement of the selected live or stored value. With `INVERT`=0, the value passes unchanged.
- R10: A synchronous active-high `rst` clears both registers to 0 and clears the previous strobe samples to 0.
- R11: Capturing a bus that the block is driving stores the value the block drives onto it, not the value on its input vector.
- R12: A strobe held high for several clocks causes exactly one capture, on its first high clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| xfer_en_n | input | 1 | Transfer enable, active low |
| dir_to_b | input | 1 | 1: block drives bus B; 0: block drives bus A |
| grab_a | input | 1 | Capture strobe for the A-side register |
| grab_b | input | 1 | Capture strobe for the B-side register |
| use_stored_ab | input | 1 | When B is driven: 0 live A, 1 A-side register |
| use_stored_ba | input | 1 | When A is driven: 0 live B, 1 B-side register |
| a_in | input | WIDTH | Value present on bus A from outside |
| a_out | output | WIDTH | Value the block drives on bus A (0 when not driving) |
| a_oe | output | WIDTH | Per-bit drive enable for bus A |
| b_in | input | WIDTH | Value present on bus B from outside |
| b_out | output | WIDTH | Value the block drives on bus B (0 when not driving) |
| b_oe | output | WIDTH | Per-bit drive enable for bus B |

## Verification
The bench builds two copies with the default width of 8 and feeds them identical stimulus. One copy has `INVERT`=0 and the other has `INVERT`=1, so every live and stored path is checked both unchanged and complemented. It also shows that the self-loop capture keeps the driven, already complemented word. Using the default width keeps the 8-bit patterns short while still letting alternating and all-ones patterns expose swapped or stuck bits.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;

    typedef enum logic [1:0] {
        DRIVE_NONE = 2'b00,
        DRIVE_A    = 2'b01,
        DRIVE_B    = 2'b10
    } drive_e;

    function automatic drive_e pick_drive(input logic en_n, input logic to_b);
        if (en_n)      return DRIVE_NONE;
        else if (to_b) return DRIVE_B;
        else           return DRIVE_A;
    endfunction

endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe_i,
    input  logic [WIDTH-1:0] bus_i,
    output logic [WIDTH-1:0] word_o
);

    typedef struct packed {
        logic [WIDTH-1:0] word;
        logic             prev;
    } cap_state_t;

    cap_state_t state_d, state_q;
    logic       rise;

    always_comb begin
        state_d      = state_q;
        rise         = strobe_i & ~state_q.prev;
        state_d.prev = strobe_i;
        if (rise) begin
            state_d.word = bus_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign word_o = state_q.word;

    // R1 R2 R7: a detected edge loads the bus value seen at that clock
    assert_edge_loads_R1: assert property (@(posedge clk) disable iff (rst)
        rise |=> (word_o == $past(bus_i)));

    // R8 R12: without a fresh edge the stored word does not move
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(word_o));

    // R10: reset clears the stored word
    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (word_o == '0));

endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
    parameter int WIDTH  = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic             en_i,
    input  logic             sel_i,
    input  logic [WIDTH-1:0] live_i,
    input  logic [WIDTH-1:0] stored_i,
    output logic [WIDTH-1:0] data_o,
    output logic [WIDTH-1:0] oe_o
);

    logic [WIDTH-1:0] chosen;
    logic [WIDTH-1:0] shaped;

    always_comb begin
        chosen = sel_i ? stored_i : live_i;
    end

    generate
        if (INVERT) begin : g_inv
            assign shaped = ~chosen;
        end else begin : g_pass
            assign shaped = chosen;
        end
    endgenerate

    assign data_o = en_i ? shaped : '0;
    assign oe_o   = {WIDTH{en_i}};

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
    import regbus_xcvr_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xfer_en_n,
    input  logic             dir_to_b,
    input  logic             grab_a,
    input  logic             grab_b,
    input  logic             use_stored_ab,
    input  logic             use_stored_ba,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe
);

    drive_e           mode;
    logic             a_en, b_en;
    logic [WIDTH-1:0] a_word, b_word;
    logic [WIDTH-1:0] a_data, b_data;
    logic [WIDTH-1:0] a_bus, b_bus;

    always_comb begin
        mode = pick_drive(xfer_en_n, dir_to_b);
        a_en = (mode == DRIVE_A);
        b_en = (mode == DRIVE_B);
    end

    // A bus that the block drives carries the driven value (self-loop capture)
    assign a_bus = a_en ? a_data : a_in;
    assign b_bus = b_en ? b_data : b_in;

    xcvr_capture #(.WIDTH(WIDTH)) cap_a_i (
        .clk     (clk),
        .rst     (rst),
        .strobe_i(grab_a),
        .bus_i   (a_bus),
        .word_o  (a_word)
    );

    xcvr_capture #(.WIDTH(WIDTH)) cap_b_i (
        .clk     (clk),
        .rst     (rst),
        .strobe_i(grab_b),
        .bus_i   (b_bus),
        .word_o  (b_word)
    );

    xcvr_drive #(.WIDTH(WIDTH), .INVERT(INVERT)) drv_a_i (
        .en_i    (a_en),
        .sel_i   (use_stored_ba),
        .live_i  (b_in),
        .stored_i(b_word),
        .data_o  (a_data),
        .oe_o    (a_oe)
    );

    xcvr_drive #(.WIDTH(WIDTH), .INVERT(INVERT)) drv_b_i (
        .en_i    (b_en),
        .sel_i   (use_stored_ab),
        .live_i  (a_in),
        .stored_i(a_word),
        .data_o  (b_data),
        .oe_o    (b_oe)
    );

    assign a_out = a_data;
    assign b_out = b_data;

    // R3: disabled transfer leaves both buses undriven
    assert_isolated_R3: assert property (@(posedge clk) disable iff (rst)
        xfer_en_n |-> ((a_oe == '0) && (b_oe == '0)));

    // R4 R6: never both buses driven at once
    assert_single_driver_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({|a_oe, |b_oe}));

    // R4: enabled toward A drives every bit of A
    assert_drive_a_R4: assert property (@(posedge clk) disable iff (rst)
        (!xfer_en_n && !dir_to_b) |-> (&a_oe));

endmodule

// File: tb/regbus_xcvr_tb_top.sv
module regbus_xcvr_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en_n = 1'b1, to_b = 1'b0, ga = 1'b0, gb = 1'b0;
    logic         s_ab = 1'b0, s_ba = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    logic [W-1:0] ia_out, ia_oe, ib_out, ib_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    regbus_xcvr #(.WIDTH(W), .INVERT(1'b0)) dut_i (
        .clk(clk), .rst(rst), .xfer_en_n(en_n), .dir_to_b(to_b),
        .grab_a(ga), .grab_b(gb), .use_stored_ab(s_ab), .use_stored_ba(s_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

    regbus_xcvr #(.WIDTH(W), .INVERT(1'b1)) dut_inv_i (
        .clk(clk), .rst(rst), .xfer_en_n(en_n), .dir_to_b(to_b),
        .grab_a(ga), .grab_b(gb), .use_stored_ab(s_ab), .use_stored_ba(s_ba),
        .a_in(a_in), .a_out(ia_out), .a_oe(ia_oe),
        .b_in(b_in), .b_out(ib_out), .b_oe(ib_oe));

    // {en_n, to_b, s_ab, s_ba, a_in[8], b_in[8], exp_a_oe, exp_b_oe, exp_out[8]}
    // registers hold A=3C, B=A5 while this table runs
    localparam logic [29:0] TBL [6] = '{
        {4'b1000, 8'h11, 8'h22, 2'b00, 8'h00},   // R3 isolation
        {4'b0000, 8'h00, 8'h22, 2'b10, 8'h22},   // R4 live B to A
        {4'b0001, 8'h00, 8'h6B, 2'b10, 8'hA5},   // R5 stored B to A
        {4'b0100, 8'h5A, 8'h00, 2'b01, 8'h5A},   // R6 live A to B
        {4'b0110, 8'h5A, 8'h00, 2'b01, 8'h3C},   // R6 stored A to B
        {4'b1111, 8'hF0, 8'h0F, 2'b00, 8'h00}    // R3 isolation
    };

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // checks B driven from the A-side register on both copies
    task automatic show_a_reg(input string req, input logic [W-1:0] exp);
        en_n = 1'b0; to_b = 1'b1; s_ab = 1'b1; a_in = '0; b_in = '0;
        #1;
        chk(req, b_out, exp);
        chk({req, " inv R9"}, ib_out, ~exp);
    endtask

    task automatic show_b_reg(input string req, input logic [W-1:0] exp);
        en_n = 1'b0; to_b = 1'b0; s_ba = 1'b1; a_in = '0; b_in = '0;
        #1;
        chk(req, a_out, exp);
        chk({req, " inv R9"}, ia_out, ~exp);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        // R10: both registers are zero after reset
        show_a_reg("R10 A reg reset", 8'h00);
        show_b_reg("R10 B reg reset", 8'h00);

        // R1 R12 R7: capture A under isolation; strobe held high does not recapture
        en_n = 1'b1; a_in = 8'h3C; ga = 1'b1;
        tick(1);
        a_in = 8'h77;
        tick(3);
        ga = 1'b0;
        tick(1);
        show_a_reg("R1 R12 A capture once", 8'h3C);

        // R2: capture B under isolation
        en_n = 1'b1; b_in = 8'hA5; gb = 1'b1;
        tick(1);
        gb = 1'b0;
        tick(1);
        show_b_reg("R2 B capture", 8'hA5);

        // table walk: combinational paths, no clock between stimulus and check
        for (int k = 0; k < 6; k++) begin
            logic [29:0] v;
            v = TBL[k];
            en_n = v[29]; to_b = v[28]; s_ab = v[27]; s_ba = v[26];
            a_in = v[25:18]; b_in = v[17:10];
            #1;
            chk("R3 R4 R6 a_oe", a_oe, {W{v[9]}});
            chk("R3 R4 R6 b_oe", b_oe, {W{v[8]}});
            chk("R3 R4 R6 inv a_oe", ia_oe, {W{v[9]}});
            chk("R3 R4 R6 inv b_oe", ib_oe, {W{v[8]}});
            if (v[9]) begin
                chk("R4 R5 a_out", a_out, v[7:0]);
                chk("R9 R4 R5 inv a_out", ia_out, ~v[7:0]);
            end
            if (v[8]) begin
                chk("R6 b_out", b_out, v[7:0]);
                chk("R9 R6 inv b_out", ib_out, ~v[7:0]);
            end
            tick(1);
        end

        // R7: both strobes rise together in isolation
        en_n = 1'b1; a_in = 8'hC3; b_in = 8'h81; ga = 1'b1; gb = 1'b1;
        tick(1);
        ga = 1'b0; gb = 1'b0;
        tick(1);
        show_a_reg("R7 joint A", 8'hC3);
        show_b_reg("R7 joint B", 8'h81);

        // R8: no edges, buses change, registers hold
        en_n = 1'b1; a_in = 8'hFF; b_in = 8'h00;
        tick(2);
        a_in = 8'h12; b_in = 8'hED;
        tick(2);
        show_a_reg("R8 A holds", 8'hC3);
        show_b_reg("R8 B holds", 8'h81);

        // R7: capture B while bus A is being driven
        en_n = 1'b0; to_b = 1'b0; s_ba = 1'b0; a_in = '0; b_in = 8'h4D; gb = 1'b1;
        tick(1);
        gb = 1'b0;
        tick(1);
        show_b_reg("R7 B capture while A driven", 8'h4D);

        // R11: capture B while the block drives B live from A
        en_n = 1'b0; to_b = 1'b1; s_ab = 1'b0; a_in = 8'hE7; b_in = 8'h00;
        #1;
        chk("R11 live drive", b_out, 8'hE7);
        chk("R11 R9 inv live drive", ib_out, 8'h18);
        gb = 1'b1;
        tick(1);
        gb = 1'b0;
        tick(1);
        // plain copy stored E7; inverting copy stored 18 and shows ~18 = E7
        en_n = 1'b0; to_b = 1'b0; s_ba = 1'b1; a_in = '0; b_in = '0;
        #1;
        chk("R11 self-loop stored", a_out, 8'hE7);
        chk("R11 R9 inv self-loop stored", ia_out, 8'hE7);

        // R12: strobe already high through reset release captures once at first high after reset
        tick(1);
        rst = 1'b1; en_n = 1'b1; a_in = 8'h99; ga = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(1);
        a_in = 8'h44;
        tick(2);
        ga = 1'b0;
        tick(1);
        show_a_reg("R12 R10 capture after reset", 8'h99);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule